// File: doc/BRIEF.md
# Programmable Color Space Matrix

This block turns a stream of 12-bit pixel triplets from one color space into another, for instance RGB into YCbCr or back. Each of the three output channels forms a weighted sum of the three input components, using its own three signed coefficients. It then adds a signed per-channel offset and applies one power-of-two gain that all channels share. The result is rounded to the nearest integer code and limited to the 12-bit output range.

The datapath accepts one pixel on every clock and delivers it a fixed three cycles later. A valid strobe and a small group of sync sideband bits (for example horizontal sync, vertical sync and data enable) travel beside the pixel through an equal delay, so timing relationships in the stream are preserved. The coefficients, offsets and gain setting come from static configuration ports. They are meant to change only while no valid pixel is in flight.

Top module: `csc_matrix_top`

## Requirements
- R1: Output channel k (k = 0, 1, 2) equals round((in_rcr*C[k][0] + in_gy*C[k][1] + in_bcb*C[k][2] + O[k]*4096) * G / 4096), clamped to 0..4095. C[k][j] is the 13-bit field cfg_coef[13*(3k+j) +: 13], O[k] is cfg_offset[13*k +: 13], and G is the gain. Pixel inputs are unsigned.
- R2: Every coefficient and offset field is read as 13-bit two's complement, so each one can take any value from -4096 to +4095.
- R3: cfg_gain_mode selects the gain G: value 0 gives G=1, 1 gives G=2, 2 gives G=4, and 3 behaves the same as 2 (G=4).
- R4: Rounding is to the nearest code, and an exact half rounds toward positive infinity (0.5 becomes 1, -0.5 becomes 0).
- R5: A rounded result below 0 is output as 0.
- R6: A rounded result above 4095 is output as 4095.
- R7: A pixel sampled with in_valid high on clock edge n appears on the data outputs with out_valid high after edge n+3. One pixel is accepted per clock with no stall, and out_valid equals in_valid delayed by three cycles.
- R8: out_sync equals in_sync delayed by three cycles, whatever the state of the valid strobe.
- R9: While out_valid is low, every data output keeps the value of the last valid pixel, and input data presented with in_valid low has no effect.
- R10: While rst_n is low, out_valid, out_sync and all three data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gain_mode | input | 2 | Shared gain select (see R3) |
| cfg_coef | input | 117 | Nine 13-bit signed coefficients, field 3k+j weights input j for channel k |
| cfg_offset | input | 39 | Three 13-bit signed offsets in output-code units, field k for channel k |
| in_rcr | input | 12 | Red or Cr input component |
| in_gy | input | 12 | Green or Y input component |
| in_bcb | input | 12 | Blue or Cb input component |
| in_valid | input | 1 | Input pixel valid |
| in_sync | input | 3 | Sync sideband bits travelling with the pixel |
| out_ch0 | output | 12 | Output channel 0 |
| out_ch1 | output | 12 | Output channel 1 |
| out_ch2 | output | 12 | Output channel 2 |
| out_valid | output | 1 | Output pixel valid |
| out_sync | output | 3 | Delayed sync sideband bits |

## Verification
A product or accumulator held in the wrong register shows up exactly three cycles after the affected pixel enters, as a wrong code on one channel. A fault in the gain or offset stage shows up one cycle earlier in the pipeline, but it also reaches the ports at the third edge. A slip in the valid or sync delay line misaligns out_valid or out_sync by a whole cycle against the data. A stage that loads while its valid bit is low shows up as a data output that changes during a gap in the stream. Saturation faults show up only at the extremes, so offsets and gains are set to drive results past both ends of the range.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;

  // Gain selection shared by all three output channels.
  typedef enum logic [1:0] {
    GAIN_X1  = 2'd0,
    GAIN_X2  = 2'd1,
    GAIN_X4  = 2'd2,
    GAIN_X4B = 2'd3
  } gain_mode_e;

  // Fixed number of register stages from input to output.
  localparam int unsigned PIPE_LAT = 3;

  // Left shift applied to the accumulated sum for a gain mode.
  function automatic logic [1:0] gain_shift(input logic [1:0] mode);
    case (gain_mode_e'(mode))
      GAIN_X1: return 2'd0;
      GAIN_X2: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/csc_side_pipe.sv
`timescale 1ns/1ps
// Delay line for the valid strobe (bit 0) and the sync sidebands.
module csc_side_pipe #(
  parameter int W     = 4,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     d_in,
  output logic [DEPTH-1:0] tap_vld,
  output logic [W-1:0]     q_out
);

  localparam int VLD_BIT = 0;

  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d_in;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    assign tap_vld[k] = stg[k][VLD_BIT];
  end

  assign q_out = stg[DEPTH-1];

endmodule

// File: rtl/csc_mac_row.sv
`timescale 1ns/1ps
// One output channel: three products, offset, gain, rounding and clamping.
module csc_mac_row #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 13,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_in,
  input  logic              v_s1,
  input  logic              v_s2,
  input  logic [DATA_W-1:0] px_a,
  input  logic [DATA_W-1:0] px_b,
  input  logic [DATA_W-1:0] px_c,
  input  logic [COEF_W-1:0] cf_a,
  input  logic [COEF_W-1:0] cf_b,
  input  logic [COEF_W-1:0] cf_c,
  input  logic [COEF_W-1:0] ofs,
  input  logic [1:0]        shift,
  output logic [DATA_W-1:0] out_q
);

  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int OFS_W  = COEF_W + FRAC_W;
  localparam int ACC_W  = ((PROD_W > OFS_W) ? PROD_W : OFS_W) + 3;
  localparam int GAIN_W = ACC_W + 3;
  localparam logic signed [GAIN_W-1:0] HALF   = GAIN_W'(2 ** (FRAC_W - 1));
  localparam logic signed [GAIN_W-1:0] MAX_Q  = GAIN_W'(2 ** DATA_W - 1);
  localparam logic signed [GAIN_W-1:0] OVER_T = GAIN_W'(2 ** (DATA_W + FRAC_W));

  // Unsigned pixel times signed coefficient.
  function automatic logic signed [PROD_W-1:0] mul_px(
    input logic [DATA_W-1:0] px,
    input logic [COEF_W-1:0] cf
  );
    logic signed [PROD_W-1:0] a;
    logic signed [PROD_W-1:0] b;
    a = PROD_W'($signed({1'b0, px}));
    b = PROD_W'($signed(cf));
    return a * b;
  endfunction

  // Sum of products plus scaled offset, gain applied, half LSB added.
  function automatic logic signed [GAIN_W-1:0] sum_gain(
    input logic signed [PROD_W-1:0] p0,
    input logic signed [PROD_W-1:0] p1,
    input logic signed [PROD_W-1:0] p2,
    input logic [COEF_W-1:0]        o,
    input logic [1:0]               sh
  );
    logic signed [ACC_W-1:0]  acc;
    logic signed [GAIN_W-1:0] g;
    acc = ACC_W'(p0) + ACC_W'(p1) + ACC_W'(p2)
        + (ACC_W'($signed(o)) <<< FRAC_W);
    g = GAIN_W'(acc) <<< sh;
    return g + HALF;
  endfunction

  // Drop the fraction and saturate into the output code range.
  function automatic logic [DATA_W-1:0] round_clamp(
    input logic signed [GAIN_W-1:0] g
  );
    logic signed [GAIN_W-1:0] q;
    q = g >>> FRAC_W;
    if (q[GAIN_W-1])  return '0;
    else if (q > MAX_Q) return '1;
    else              return q[DATA_W-1:0];
  endfunction

  logic signed [PROD_W-1:0] pa_s1, pb_s1, pc_s1;
  logic signed [GAIN_W-1:0] g_s2;

  // Stage 1: products.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_s1 <= '0;
      pb_s1 <= '0;
      pc_s1 <= '0;
    end else if (v_in) begin
      pa_s1 <= mul_px(px_a, cf_a);
      pb_s1 <= mul_px(px_b, cf_b);
      pc_s1 <= mul_px(px_c, cf_c);
    end
  end

  // Stage 2: accumulate, offset, gain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    g_s2 <= '0;
    else if (v_s1) g_s2 <= sum_gain(pa_s1, pb_s1, pc_s1, ofs, shift);
  end

  // Stage 3: round and clamp.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_q <= '0;
    else if (v_s2) out_q <= round_clamp(g_s2);
  end

  // Events of stage 2 that decide saturation at stage 3.
  logic s2_below;
  logic s2_above;
  assign s2_below = g_s2[GAIN_W-1];
  assign s2_above = !g_s2[GAIN_W-1] && (g_s2 >= OVER_T);

  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (v_s2 && s2_below) |=> (out_q == '0)); // R5
  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (v_s2 && s2_above) |=> (out_q == {DATA_W{1'b1}})); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_s2) |=> $stable(out_q)); // R9

endmodule

// File: rtl/csc_matrix_top.sv
`timescale 1ns/1ps
module csc_matrix_top #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 13,
  parameter int FRAC_W = 12,
  parameter int SYNC_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_gain_mode,
  input  logic [9*COEF_W-1:0]   cfg_coef,
  input  logic [3*COEF_W-1:0]   cfg_offset,
  input  logic [DATA_W-1:0]     in_rcr,
  input  logic [DATA_W-1:0]     in_gy,
  input  logic [DATA_W-1:0]     in_bcb,
  input  logic                  in_valid,
  input  logic [SYNC_W-1:0]     in_sync,
  output logic [DATA_W-1:0]     out_ch0,
  output logic [DATA_W-1:0]     out_ch1,
  output logic [DATA_W-1:0]     out_ch2,
  output logic                  out_valid,
  output logic [SYNC_W-1:0]     out_sync
);

  localparam int N_CH   = 3;
  localparam int SIDE_W = SYNC_W + 1;
  localparam int LAT    = int'(csc_pkg::PIPE_LAT);

  logic [1:0]        gain_sh;
  logic [LAT-1:0]    vld_tap;
  logic [SIDE_W-1:0] side_q;
  logic [DATA_W-1:0] row_q [N_CH];

  assign gain_sh = csc_pkg::gain_shift(cfg_gain_mode);

  csc_side_pipe #(.W(SIDE_W), .DEPTH(LAT)) u_side (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_in    ({in_sync, in_valid}),
    .tap_vld (vld_tap),
    .q_out   (side_q)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_row
    csc_mac_row #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .v_in  (in_valid),
      .v_s1  (vld_tap[0]),
      .v_s2  (vld_tap[1]),
      .px_a  (in_rcr),
      .px_b  (in_gy),
      .px_c  (in_bcb),
      .cf_a  (cfg_coef[COEF_W*(3*k+0) +: COEF_W]),
      .cf_b  (cfg_coef[COEF_W*(3*k+1) +: COEF_W]),
      .cf_c  (cfg_coef[COEF_W*(3*k+2) +: COEF_W]),
      .ofs   (cfg_offset[COEF_W*k +: COEF_W]),
      .shift (gain_sh),
      .out_q (row_q[k])
    );
  end

  assign out_ch0   = row_q[0];
  assign out_ch1   = row_q[1];
  assign out_ch2   = row_q[2];
  assign out_valid = side_q[0];
  assign out_sync  = side_q[SIDE_W-1:1];

  // Cycles seen since reset release, saturating once the pipe is full.
  logic [1:0] since_rst;
  logic       lat_full;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign lat_full = (since_rst == 2'd3);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lat_full |-> (out_valid == $past(in_valid, 3))); // R7
  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lat_full |-> (out_sync == $past(in_sync, 3))); // R8

endmodule

// File: tb/csc_matrix_top_test.sv
`timescale 1ns/1ps
module csc_matrix_top_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cfg_gain_mode;
  logic [116:0] cfg_coef;
  logic [38:0]  cfg_offset;
  logic [11:0]  in_rcr = '0, in_gy = '0, in_bcb = '0;
  logic         in_valid = 1'b0;
  logic [2:0]   in_sync = '0;
  logic [11:0]  out_ch0, out_ch1, out_ch2;
  logic         out_valid;
  logic [2:0]   out_sync;

  int k_coef [9];
  int k_ofs  [3];
  int k_mode;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  string phase_tag = "R1";

  // Expected-value history, index 0 is the newest pixel.
  logic        h_v [3];
  logic [2:0]  h_s [3];
  logic [11:0] h_d [3][3];
  logic [11:0] last_d [3];

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 9; i++) cfg_coef[13*i +: 13] = 13'(k_coef[i]);
    for (int i = 0; i < 3; i++) cfg_offset[13*i +: 13] = 13'(k_ofs[i]);
    cfg_gain_mode = 2'(k_mode);
  end

  csc_matrix_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_gain_mode(cfg_gain_mode),
    .cfg_coef(cfg_coef), .cfg_offset(cfg_offset),
    .in_rcr(in_rcr), .in_gy(in_gy), .in_bcb(in_bcb),
    .in_valid(in_valid), .in_sync(in_sync),
    .out_ch0(out_ch0), .out_ch1(out_ch1), .out_ch2(out_ch2),
    .out_valid(out_valid), .out_sync(out_sync)
  );

  // Reference: exact arithmetic in reals, then nearest with ties upward.
  function automatic logic [11:0] model_row(input int r, input int g, input int b,
                                            input int ch);
    longint acc;
    longint q;
    real    v;
    int     gain;
    gain = (k_mode == 0) ? 1 : (k_mode == 1) ? 2 : 4;
    acc = longint'(r) * k_coef[3*ch] + longint'(g) * k_coef[3*ch+1]
        + longint'(b) * k_coef[3*ch+2] + longint'(k_ofs[ch]) * 4096;
    v = $floor(real'(acc * gain) / 4096.0 + 0.5);
    q = longint'(v);
    if (q < 0) return 12'd0;
    if (q > 4095) return 12'd4095;
    return 12'(q);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [11:0] o [3];
    o[0] = out_ch0; o[1] = out_ch1; o[2] = out_ch2;
    chk("R7 valid", 32'(out_valid), 32'(h_v[2]));
    chk("R8 sync", 32'(out_sync), 32'(h_s[2]));
    for (int c = 0; c < 3; c++) begin
      if (h_v[2]) begin
        chk({phase_tag, " data"}, 32'(o[c]), 32'(h_d[2][c]));
        last_d[c] = h_d[2][c];
      end else begin
        chk("R9 hold", 32'(o[c]), 32'(last_d[c]));
      end
    end
  endtask

  task automatic step(input bit v, input int r, input int g, input int b);
    @(negedge clk);
    compare();
    for (int i = 2; i > 0; i--) begin
      h_v[i] = h_v[i-1];
      h_s[i] = h_s[i-1];
      for (int c = 0; c < 3; c++) h_d[i][c] = h_d[i-1][c];
    end
    in_valid = v;
    in_rcr = 12'(r); in_gy = 12'(g); in_bcb = 12'(b);
    in_sync = 3'($urandom_range(7));
    h_v[0] = v;
    h_s[0] = in_sync;
    for (int c = 0; c < 3; c++) h_d[0][c] = model_row(r, g, b, c);
  endtask

  task automatic rand_px(input int n, input int pct_valid);
    for (int i = 0; i < n; i++)
      step(($urandom_range(99) < pct_valid), $urandom_range(4095),
           $urandom_range(4095), $urandom_range(4095));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      step(1'b0, $urandom_range(4095), $urandom_range(4095), $urandom_range(4095));
  endtask

  task automatic set_cfg(input int md, input int c0, input int c1, input int c2,
                         input int c3, input int c4, input int c5,
                         input int c6, input int c7, input int c8,
                         input int o0, input int o1, input int o2);
    idle(4);
    k_mode = md;
    k_coef[0] = c0; k_coef[1] = c1; k_coef[2] = c2;
    k_coef[3] = c3; k_coef[4] = c4; k_coef[5] = c5;
    k_coef[6] = c6; k_coef[7] = c7; k_coef[8] = c8;
    k_ofs[0] = o0; k_ofs[1] = o1; k_ofs[2] = o2;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5171));
    k_mode = 0;
    for (int i = 0; i < 9; i++) k_coef[i] = 0;
    for (int i = 0; i < 3; i++) k_ofs[i] = 0;
    for (int i = 0; i < 3; i++) begin
      h_v[i] = 1'b0; h_s[i] = '0; last_d[i] = '0;
      for (int c = 0; c < 3; c++) h_d[i][c] = '0;
    end

    // R10: quiet outputs while reset is held, even with inputs toggling.
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sync = 3'b111; in_rcr = 12'hFFF;
      chk("R10 reset valid", 32'(out_valid), 32'd0);
      chk("R10 reset sync", 32'(out_sync), 32'd0);
      chk("R10 reset ch0", 32'(out_ch0), 32'd0);
      chk("R10 reset ch1", 32'(out_ch1), 32'd0);
      chk("R10 reset ch2", 32'(out_ch2), 32'd0);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sync = '0; in_rcr = '0;
    rst_n = 1'b1;

    // R3: gain modes with a pass-through matrix.
    phase_tag = "R3 gain x2";
    set_cfg(1, 2048,0,0, 0,2048,0, 0,0,2048, 0,0,0);
    rand_px(40, 100);
    phase_tag = "R3 gain mode3";
    set_cfg(3, 1024,0,0, 0,1024,0, 0,0,1024, 0,0,0);
    rand_px(40, 80);
    phase_tag = "R3 gain x4";
    set_cfg(2, 1024,512,0, 0,1024,-512, 300,0,1024, 5,-7,0);
    rand_px(40, 80);
    phase_tag = "R3 gain x1";
    set_cfg(0, 4095,0,0, 0,4095,0, 0,0,4095, 0,0,0);
    rand_px(40, 80);

    // R1: RGB to YCbCr style matrix, gaps in the stream.
    phase_tag = "R1";
    set_cfg(0, 1225,2404,467, -691,-1357,2048, 2048,-1715,-333, 0,2048,2048);
    step(1'b1, 4095, 4095, 4095);
    step(1'b1, 0, 0, 0);
    step(1'b1, 4095, 0, 0);
    step(1'b1, 0, 0, 4095);
    rand_px(300, 70);

    // R4: exact halves round upward.
    phase_tag = "R4";
    set_cfg(0, 2048,0,0, -2048,0,0, 0,1,0, 0,1,0);
    for (int r = 0; r < 8; r++) step(1'b1, r, r, 0);
    step(1'b1, 0, 2048, 0);
    step(1'b1, 0, 2047, 0);
    rand_px(60, 90);

    // R5: large negative offsets force the low clamp.
    phase_tag = "R5";
    set_cfg(0, 100,0,0, 0,-4096,0, 0,0,4095, -4096,-1,-4096);
    rand_px(80, 90);

    // R6: large positive offsets and gain force the high clamp.
    phase_tag = "R6";
    set_cfg(2, 4095,4095,4095, 0,0,0, -4096,0,0, 4095,1024,4095);
    step(1'b1, 0, 0, 0);
    rand_px(80, 90);

    // R2: full signed ranges, random modes and offsets.
    phase_tag = "R2";
    for (int n = 0; n < 10; n++) begin
      set_cfg($urandom_range(3),
              $urandom_range(8191) - 4096, $urandom_range(8191) - 4096,
              $urandom_range(8191) - 4096, $urandom_range(8191) - 4096,
              $urandom_range(8191) - 4096, $urandom_range(8191) - 4096,
              $urandom_range(8191) - 4096, $urandom_range(8191) - 4096,
              $urandom_range(8191) - 4096,
              $urandom_range(8191) - 4096, $urandom_range(8191) - 4096,
              $urandom_range(8191) - 4096);
      if (n == 0) begin
        k_coef[0] = -4096; k_coef[4] = 4095; k_coef[8] = -4096;
      end
      rand_px(150, 60);
    end

    idle(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule